// File: doc/BRIEF.md
# Word and Halfword Load/Store Unit

This unit sits between the execute stage of a pipeline and a data memory that is 32 bits wide and word-addressed. For each memory operation it adds the sign-extended 16-bit displacement to the base register value. It turns the resulting byte address into a word index and a lane choice. It then drives one synchronous memory port. Stores go out as byte-enabled writes. Loads go out as full-word reads, and the unit shapes the returned word into a register write-back value.

Four operations are handled: full-word load, unsigned halfword load, full-word store and halfword store. Halfword traffic uses the word-wide port. On a store the unit steers the 16-bit value into the selected half of the word and raises only that half's two byte enables. On a load it picks the selected half of the returned word and zero-extends it. Requests arrive on a valid/ready channel. The unit never applies back-pressure, so `req_ready` is held high and a request is accepted in every cycle in which `req_valid` is high. The write-back side is a plain one-cycle strobe with no ready, because the register file always accepts it.

Top module: `ldst_unit`

## Requirements
- R1: While reset is held and after it is released with no request, `wb_valid`, `mem_en` and `mem_we` are low and `req_ready` is high.
- R2: The byte address is `req_base + sign_extend(req_offset)`. `mem_addr` equals byte-address bits [WORD_AW+1:2]. Bits 1:0 have no effect on word accesses, and bit 0 has no effect on halfword accesses.
- R3: A word load (opcode 0x23) drives `mem_en`=1 and `mem_we`=0. One cycle later it returns the whole read word on `wb_data`, with `wb_rt` equal to the request's `req_rt`.
- R4: An unsigned halfword load (opcode 0x25) returns bits [15:0] of the read word when byte-address bit 1 is 0, and bits [31:16] when it is 1. The value appears in `wb_data[15:0]` with `wb_data[31:16]` zero.
- R5: A word store (opcode 0x2B) drives `mem_en`=1, `mem_we`=1, `mem_be`=4'b1111 and `mem_wdata` equal to `req_rt_data`.
- R6: A halfword store (opcode 0x29) drives `mem_we`=1. When address bit 1 is 0, `mem_be` is 4'b0011 and `req_rt_data[15:0]` is in `mem_wdata[15:0]`. When address bit 1 is 1, `mem_be` is 4'b1100 and the same 16 bits are in `mem_wdata[31:16]`. The other half of the memory word is left unchanged.
- R7: Any other opcode, or any cycle with `req_valid` low, makes no memory access, causes no write-back and leaves memory contents unchanged.
- R8: `req_ready` is always high. Back-to-back requests of any mix are each accepted in their own cycle. A store issued in the same cycle as a load's write-back performs both.
- R9: `wb_valid` is high in exactly those cycles that directly follow a cycle in which a load was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit accepts a request (always high) |
| req_opcode | input | 6 | Operation code of the request |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed byte displacement |
| req_rt | input | RIDX_W | Destination register index for loads |
| req_rt_data | input | 32 | Store data register value |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_be | output | 4 | Byte write enables |
| mem_addr | output | WORD_AW | Word index |
| mem_wdata | output | 32 | Write data, lane-steered |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |
| wb_valid | output | 1 | Register write strobe |
| wb_rt | output | RIDX_W | Register index to write |
| wb_data | output | 32 | Value to write |

## Verification
The overlap that matters is a load's write-back landing in the same cycle as the next request's memory access. The unit must then shape returned data for one operation while it steers lanes and enables for another. The bench provokes this by pairing every halfword store with an unsigned halfword load of the same location issued one cycle earlier. The write-back during the store cycle must carry the old halfword, and a later sweep of loads must see the new one with the neighbouring half untouched. Runs of word loads with no gap make each cycle both a write-back and a new read, and each write-back is compared with the arithmetic pattern stored at that index.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam logic [5:0] OPC_LDW = 6'h23;
  localparam logic [5:0] OPC_LDH = 6'h25;
  localparam logic [5:0] OPC_STH = 6'h29;
  localparam logic [5:0] OPC_STW = 6'h2B;

  typedef enum logic [2:0] {
    ACC_NONE = 3'd0,
    ACC_LDW  = 3'd1,
    ACC_LDH  = 3'd2,
    ACC_STW  = 3'd3,
    ACC_STH  = 3'd4
  } acc_e;

  function automatic acc_e classify(input logic [5:0] opc);
    case (opc)
      OPC_LDW: return ACC_LDW;
      OPC_LDH: return ACC_LDH;
      OPC_STW: return ACC_STW;
      OPC_STH: return ACC_STH;
      default: return ACC_NONE;
    endcase
  endfunction

  function automatic logic acc_is_load(input acc_e k);
    return (k == ACC_LDW) || (k == ACC_LDH);
  endfunction

  function automatic logic acc_is_store(input acc_e k);
    return (k == ACC_STW) || (k == ACC_STH);
  endfunction

endpackage

// File: rtl/ldst_agen.sv
module ldst_agen #(
  parameter int WORD_AW = 16
) (
  input  logic [31:0]        base,
  input  logic [15:0]        offset,
  output logic [WORD_AW-1:0] word_addr,
  output logic               half_sel
);
  localparam int BYTE_AW = WORD_AW + 2;

  logic [31:0] ea;
  logic        unused_ea_bits;

  assign ea             = base + {{16{offset[15]}}, offset};
  assign word_addr      = ea[BYTE_AW-1:2];
  assign half_sel       = ea[1];
  assign unused_ea_bits = ^{ea[31:BYTE_AW], ea[0]};
endmodule

// File: rtl/ldst_store_lane.sv
module ldst_store_lane
  import ldst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  acc_e        kind,
  input  logic        half_sel,
  input  logic [31:0] rt_data,
  output logic [3:0]  be,
  output logic [31:0] wdata
);
  localparam int HALVES = 2;

  logic is_word;
  logic is_half;

  assign is_word = (kind == ACC_STW);
  assign is_half = (kind == ACC_STH);

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    logic pick;
    assign pick             = is_word | (is_half & (half_sel == 1'(g)));
    assign be[2*g +: 2]     = {2{pick}};
    assign wdata[16*g +: 16] = is_word ? rt_data[16*g +: 16] : rt_data[15:0];
  end

  // R6
  store_be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (be != 4'b0000) |-> (be == 4'b1111 || be == 4'b0011 || be == 4'b1100));
endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract (
  input  logic        is_half,
  input  logic        half_sel,
  input  logic [31:0] rdata,
  output logic [31:0] data
);
  logic [15:0] picked;

  assign picked = half_sel ? rdata[31:16] : rdata[15:0];
  assign data   = is_half ? {16'h0000, picked} : rdata;
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int WORD_AW = 16,
  parameter int RIDX_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [5:0]         req_opcode,
  input  logic [31:0]        req_base,
  input  logic [15:0]        req_offset,
  input  logic [RIDX_W-1:0]  req_rt,
  input  logic [31:0]        req_rt_data,
  output logic               mem_en,
  output logic               mem_we,
  output logic [3:0]         mem_be,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  output logic               wb_valid,
  output logic [RIDX_W-1:0]  wb_rt,
  output logic [31:0]        wb_data
);
  acc_e              kind;
  logic              ld_fire;
  logic              st_fire;
  logic              half_sel;
  logic [3:0]        st_be;
  logic [31:0]       st_wdata;

  logic              pend_valid;
  logic              pend_half;
  logic              pend_sel;
  logic [RIDX_W-1:0] pend_rt;

  assign req_ready = 1'b1;
  assign kind      = req_valid ? classify(req_opcode) : ACC_NONE;
  assign ld_fire   = acc_is_load(kind);
  assign st_fire   = acc_is_store(kind);

  ldst_agen #(.WORD_AW(WORD_AW)) u_agen (
    .base      (req_base),
    .offset    (req_offset),
    .word_addr (mem_addr),
    .half_sel  (half_sel)
  );

  ldst_store_lane u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .half_sel (half_sel),
    .rt_data  (req_rt_data),
    .be       (st_be),
    .wdata    (st_wdata)
  );

  assign mem_en    = ld_fire | st_fire;
  assign mem_we    = st_fire;
  assign mem_be    = st_fire ? st_be : (ld_fire ? 4'b1111 : 4'b0000);
  assign mem_wdata = st_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_half  <= 1'b0;
      pend_sel   <= 1'b0;
      pend_rt    <= '0;
    end else begin
      pend_valid <= ld_fire;
      if (ld_fire) begin
        pend_half <= (kind == ACC_LDH);
        pend_sel  <= half_sel;
        pend_rt   <= req_rt;
      end
    end
  end

  ldst_load_extract u_ext (
    .is_half  (pend_half),
    .half_sel (pend_sel),
    .rdata    (mem_rdata),
    .data     (wb_data)
  );

  assign wb_valid = pend_valid;
  assign wb_rt    = pend_rt;

  // R9
  wb_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |=> wb_valid);

  // R9
  wb_only_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(ld_fire));

  // R4
  lhu_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && $past(req_valid && req_opcode == OPC_LDH)) |-> (wb_data[31:16] == 16'h0000));

  // R7
  we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && req_valid));

  // R3
  load_reads_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> (mem_be == 4'b1111));
endmodule

// File: tb/tb_ldst_unit.sv
`timescale 1ns/1ps
module tb_ldst_unit;
  localparam int AW    = 6;
  localparam int WORDS = 1 << AW;
  localparam logic [5:0] LW  = 6'h23;
  localparam logic [5:0] LHU = 6'h25;
  localparam logic [5:0] SH  = 6'h29;
  localparam logic [5:0] SW  = 6'h2B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [5:0]    req_opcode = '0;
  logic [31:0]   req_base = '0;
  logic [15:0]   req_offset = '0;
  logic [4:0]    req_rt = '0;
  logic [31:0]   req_rt_data = '0;
  logic          mem_en, mem_we;
  logic [3:0]    mem_be;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata;
  logic          wb_valid;
  logic [4:0]    wb_rt;
  logic [31:0]   wb_data;

  ldst_unit #(.WORD_AW(AW), .RIDX_W(5)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_base(req_base), .req_offset(req_offset),
    .req_rt(req_rt), .req_rt_data(req_rt_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .wb_valid(wb_valid), .wb_rt(wb_rt), .wb_data(wb_data)
  );

  logic [31:0] ram [WORDS];
  logic [31:0] shadow [WORDS];

  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) ram[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= ram[mem_addr];
      end
    end
  end

  int n_checks = 0;
  int n_fails  = 0;
  logic        exp_wb = 1'b0;
  logic [4:0]  exp_rt = '0;
  logic [31:0] exp_data = '0;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h9E3779B9) ^ 32'h5A5A0F0F;
  endfunction

  // one request per call; called at a falling edge, returns at the next one
  task automatic issue(input logic [5:0] op, input logic [31:0] base, input logic [15:0] off,
                       input logic [4:0] rt, input logic [31:0] d, input logic v);
    logic [31:0] ea;
    int wi;
    logic sel;
    // write-back of the previous request (R9, R3, R4, R8)
    check(wb_valid == exp_wb, "R9 wb_valid", 32'(wb_valid), 32'(exp_wb));
    if (exp_wb) begin
      check(wb_rt == exp_rt, "R3 wb_rt", 32'(wb_rt), 32'(exp_rt));
      check(wb_data == exp_data, "R4/R3 wb_data", wb_data, exp_data);
    end
    ea  = base + {{16{off[15]}}, off};
    wi  = int'(ea[AW+1:2]);
    sel = ea[1];
    exp_wb = v && (op == LW || op == LHU);
    exp_rt = rt;
    if (op == LW) exp_data = shadow[wi];
    else exp_data = {16'h0, sel ? shadow[wi][31:16] : shadow[wi][15:0]};
    if (v && op == SW) shadow[wi] = d;
    if (v && op == SH) begin
      if (sel) shadow[wi][31:16] = d[15:0];
      else     shadow[wi][15:0]  = d[15:0];
    end
    req_valid = v; req_opcode = op; req_base = base; req_offset = off;
    req_rt = rt; req_rt_data = d;
    #1;
    check(req_ready == 1'b1, "R8 req_ready", 32'(req_ready), 32'd1);
    if (v && (op == LW || op == LHU)) begin
      check(mem_en && !mem_we, "R3 read strobe", {30'd0, mem_en, mem_we}, 32'd2);
      check(mem_addr == AW'(wi), "R2 load addr", 32'(mem_addr), 32'(wi));
    end else if (v && op == SW) begin
      check(mem_en && mem_we, "R5 write strobe", {30'd0, mem_en, mem_we}, 32'd3);
      check(mem_be == 4'b1111, "R5 be", 32'(mem_be), 32'hF);
      check(mem_wdata == d, "R5 wdata", mem_wdata, d);
      check(mem_addr == AW'(wi), "R2 store addr", 32'(mem_addr), 32'(wi));
    end else if (v && op == SH) begin
      check(mem_en && mem_we, "R6 write strobe", {30'd0, mem_en, mem_we}, 32'd3);
      check(mem_be == (sel ? 4'b1100 : 4'b0011), "R6 be", 32'(mem_be), sel ? 32'hC : 32'h3);
      check((sel ? mem_wdata[31:16] : mem_wdata[15:0]) == d[15:0], "R6 lane data",
            32'(sel ? mem_wdata[31:16] : mem_wdata[15:0]), 32'(d[15:0]));
      check(mem_addr == AW'(wi), "R2 half addr", 32'(mem_addr), 32'(wi));
    end else begin
      check(!mem_en && !mem_we, "R7 no access", {30'd0, mem_en, mem_we}, 32'd0);
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin ram[i] = 32'h0; shadow[i] = 32'h0; end
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!wb_valid && !mem_en && !mem_we, "R1 in reset", {29'd0, wb_valid, mem_en, mem_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wb_valid && !mem_en && !mem_we, "R1 after reset", {29'd0, wb_valid, mem_en, mem_we}, 32'd0);
    check(req_ready, "R1 ready", 32'(req_ready), 32'd1);

    // fill with word stores, base+offset split varies (R5, R2)
    for (int i = 0; i < WORDS; i++)
      issue(SW, 32'(4*i) + 32'd100, 16'hFF9C, 5'(i), pat(i), 1'b1);
    // back-to-back word loads, low address bits varied (R3, R2, R8)
    for (int i = 0; i < WORDS; i++)
      issue(LW, 32'(4*i), 16'(i % 4), 5'(i), 32'h0, 1'b1);
    // load then halfword store to same spot: wb coincides with store (R4, R6, R8)
    for (int i = 0; i < WORDS; i++)
      for (int l = 0; l < 2; l++) begin
        logic [31:0] ea;
        ea = 32'(4*i + 2*l + (i % 2));
        issue(LHU, ea - 32'd12, 16'd12, 5'(31 - i), 32'h0, 1'b1);
        issue(SH, ea + 32'd8, 16'hFFF8, 5'd0, {16'hBEEF, 16'(i * 977 + l * 31)}, 1'b1);
      end
    // full readback of both halves and whole words (R4, R6, R3)
    for (int i = 0; i < WORDS; i++) begin
      issue(LHU, 32'(4*i), 16'd0, 5'd1, 32'h0, 1'b1);
      issue(LHU, 32'(4*i + 3), 16'd0, 5'd2, 32'h0, 1'b1);
      issue(LW, 32'(4*i), 16'd0, 5'd3, 32'h0, 1'b1);
    end
    // other opcodes ignored (R7)
    for (int op = 0; op < 64; op++)
      if (6'(op) != LW && 6'(op) != LHU && 6'(op) != SW && 6'(op) != SH)
        issue(6'(op), 32'd8, 16'd0, 5'd4, 32'hDEADBEEF, 1'b1);
    // valid low: no store takes effect, no write-back (R7)
    issue(SW, 32'd8, 16'd0, 5'd4, 32'hDEADBEEF, 1'b0);
    issue(SH, 32'd10, 16'd0, 5'd4, 32'hDEADBEEF, 1'b0);
    issue(LW, 32'd8, 16'd0, 5'd4, 32'h0, 1'b0);
    issue(LW, 32'd8, 16'd0, 5'd5, 32'h0, 1'b1);
    issue(LW, 32'd0, 16'd0, 5'd6, 32'h0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule